// File: doc/BRIEF.md
# I2C Controller Event Flags and Interrupt Line

This block collects the transfer events reported by an I2C master's bus engine and turns them into one interrupt request. The engine raises one-cycle pulses on a 16-bit event vector. Each pulse at a recognised position sets a sticky flag in a status word. Software reads that word over a small 16-bit register port and clears flags by writing ones back to it.

A five-bit enable word selects which of the low, maskable events can raise the interrupt. The interrupt line is registered. It stays high for as long as any enabled flag is set, so a handler can keep reading and clearing until the masked status reads zero. A live bus-busy indication sits in the same status word. It follows START and STOP detections from the engine and is not affected by writes.

The register port takes one write per cycle and has no back-pressure. Reads are combinational on the selected address. Event, START and STOP inputs are plain one-cycle pulses with no handshake.

Top module: `i2c_evt_irq_ctrl`

## Requirements
- R1: After reset the status word reads 0x0000, the enable word reads 0x0000, `irq_o` is low and `bus_busy_o` is low.
- R2: A pulse on `evt_pulse_i[k]` for k in {0,1,2,3,4,8,9,10,11,15} sets status bit k one clock later. The bit then holds until it is cleared. The status word is read at address 0.
- R3: A write to address 0 clears each status bit whose `reg_wdata_i` bit is one and leaves bits written with zero unchanged.
- R4: If an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit is set after that edge.
- R5: The enable word at address 1 stores `reg_wdata_i[4:0]`. Its bits 15..5 always read zero.
- R6: `irq_o` goes high one clock after any bit of (status[4:0] AND enable[4:0]) is one. It goes low one clock after that AND becomes zero.
- R7: Bus busy sets on `bus_start_i` and clears on `bus_stop_i`. START wins when both arrive in the same cycle. The value appears on `bus_busy_o` and as status bit 12, and writes to bit 12 have no effect.
- R8: Status bits 5, 6, 7, 13 and 14 always read zero. Event pulses at those positions are ignored.
- R9: Addresses 2 and 3 read zero. Writes to them change neither word.
- R10: Status bits 8 to 11 and 15 never raise `irq_o`, even with all enable bits written to one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse_i | input | 16 | One-cycle event pulses from the bus engine, one per status position |
| bus_start_i | input | 1 | START condition detected |
| bus_stop_i | input | 1 | STOP condition detected |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 enable |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected address |
| irq_o | output | 1 | Registered, level-sensitive interrupt request |
| bus_busy_o | output | 1 | Live bus-busy flag |

## Verification
The bench aims at an event and a clear landing on the same bit in one cycle. A design where the clear wins would lose that event, and its status word would read zero where a one is expected. It also checks that the interrupt rises and falls exactly one clock after the masked status changes. An unregistered or doubly registered line would miss that cycle. It further writes all ones to the status word, the enable word and the unmapped addresses, which would expose a writable busy bit, a latched reserved bit, an unmaskable error flag that leaks into the interrupt, or an alias of the unmapped addresses.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned MASK_EVTS = 5;
  localparam int unsigned BUSY_POS = 12;
  // positions that latch an event pulse
  localparam logic [WORD_W-1:0] LATCH_MASK = 16'h8F1F;
  localparam logic [WORD_W-1:0] ENBL_MASK  = (16'h1 << MASK_EVTS) - 16'h1;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_NONE2  = 2'd2,
    SEL_NONE3  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/i2c_evt_status_bank.sv
module i2c_evt_status_bank
  import i2c_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] ev_i,
  input  logic [WORD_W-1:0] clr_i,
  output logic [WORD_W-1:0] stat_o
);
  for (genvar k = 0; k < WORD_W; k++) begin : g_bit
    if (LATCH_MASK[k]) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (ev_i[k])  flag_q <= 1'b1;
        else if (clr_i[k]) flag_q <= 1'b0;
      end
      assign stat_o[k] = flag_q;

      // R4: a pulse always leaves the flag set, clear or no clear
      a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i[k] |=> stat_o[k]);
      // R3: write-one removes a set flag when no new pulse arrives
      a_r3_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[k] && !ev_i[k]) |=> !stat_o[k]);
      // R2: without clear the flag is sticky
      a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[k] && !clr_i[k]) |=> stat_o[k]);
    end else begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ev_i[k] ^ clr_i[k];
      assign stat_o[k]   = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_evt_busy_track.sv
module i2c_evt_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  output logic busy_o
);
  logic busy_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (start_i) busy_q <= 1'b1;
    else if (stop_i)  busy_q <= 1'b0;
  end
  assign busy_o = busy_q;

  // R7: START sets busy, a lone STOP releases it
  a_r7_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !busy_o);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !stop_i) |=> $stable(busy_o));
endmodule

// File: rtl/i2c_evt_irq_mask.sv
module i2c_evt_irq_mask
  import i2c_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] stat_i,
  output logic [WORD_W-1:0] en_o,
  output logic              irq_o
);
  logic [MASK_EVTS-1:0] en_q;
  logic                 irq_q;
  logic                 unused_hi;

  assign unused_hi = ^{wdata_i[WORD_W-1:MASK_EVTS], stat_i[WORD_W-1:MASK_EVTS]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_wr_i) en_q <= wdata_i[MASK_EVTS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat_i[MASK_EVTS-1:0] & en_q);
  end

  assign en_o  = {{(WORD_W-MASK_EVTS){1'b0}}, en_q};
  assign irq_o = irq_q;

  // R6: with the enable word cleared for two cycles the line is low
  a_r6_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 && $past(en_q) == '0) |-> !irq_o);
  // R10: only the low maskable flags can keep the line high
  a_r10_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_i[MASK_EVTS-1:0]) == '0) |-> !irq_o);
endmodule

// File: rtl/i2c_evt_irq_ctrl.sv
module i2c_evt_irq_ctrl
  import i2c_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] evt_pulse_i,
  input  logic              bus_start_i,
  input  logic              bus_stop_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              bus_busy_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(SEL_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(SEL_ENABLE);

  logic              wr_status, wr_enable, busy;
  logic [WORD_W-1:0] clr_vec, stat, en_word, status_word;

  assign wr_status = reg_wr_i && (reg_addr_i == A_STATUS);
  assign wr_enable = reg_wr_i && (reg_addr_i == A_ENABLE);
  assign clr_vec   = wr_status ? reg_wdata_i : '0;

  i2c_evt_status_bank u_bank (
    .clk(clk), .rst_n(rst_n), .ev_i(evt_pulse_i), .clr_i(clr_vec), .stat_o(stat));

  i2c_evt_busy_track u_busy (
    .clk(clk), .rst_n(rst_n), .start_i(bus_start_i), .stop_i(bus_stop_i), .busy_o(busy));

  i2c_evt_irq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .en_wr_i(wr_enable), .wdata_i(reg_wdata_i),
    .stat_i(stat), .en_o(en_word), .irq_o(irq_o));

  always_comb begin
    status_word = stat;
    status_word[BUSY_POS] = busy;
  end

  always_comb begin
    if (reg_addr_i == A_STATUS)      reg_rdata_o = status_word;
    else if (reg_addr_i == A_ENABLE) reg_rdata_o = en_word;
    else                             reg_rdata_o = '0;
  end

  assign bus_busy_o = busy;

  // R8: reserved status positions never read as one
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_STATUS) |-> ((reg_rdata_o & ~(LATCH_MASK | (16'h1 << BUSY_POS))) == '0));
  // R5: upper enable bits read zero
  a_r5_enable_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_ENABLE) |-> ((reg_rdata_o & ~ENBL_MASK) == '0));
  // R7: status word busy bit mirrors the pin
  a_r7_busy_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_STATUS) |-> (reg_rdata_o[BUSY_POS] == bus_busy_o));
endmodule

// File: tb/i2c_evt_irq_ctrl_tb.sv
module i2c_evt_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        start = 1'b0, stop = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, busy;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  logic [15:0] m_stat = '0, m_en = '0;
  logic        m_busy = 1'b0, m_irq = 1'b0;

  always #2.5 clk = ~clk;

  i2c_evt_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse_i(evt), .bus_start_i(start),
    .bus_stop_i(stop), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .bus_busy_o(busy));

  always @(posedge clk) begin
    logic nxt_irq;
    if (!rst_n) begin
      m_stat = '0; m_en = '0; m_busy = 1'b0; m_irq = 1'b0;
    end else begin
      nxt_irq = (m_stat[4:0] & m_en[4:0]) != 5'd0;
      if (wr && addr == 2'd0) m_stat = m_stat & ~wdata;
      m_stat = m_stat | (evt & 16'h8F1F);
      if (wr && addr == 2'd1) m_en = {11'd0, wdata[4:0]};
      if (start) m_busy = 1'b1;
      else if (stop) m_busy = 1'b0;
      m_irq = nxt_irq;
    end
  end

  function automatic logic [15:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: exp_read = m_stat | (16'(m_busy) << 12);
      2'd1: exp_read = m_en;
      default: exp_read = 16'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every output against the reference, then drive the next inputs
  task automatic step(logic [15:0] e, logic s, logic p, logic w, logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    chk("R6 irq", {15'd0, irq}, {15'd0, m_irq});
    chk("R7 busy", {15'd0, busy}, {15'd0, m_busy});
    chk(addr == 2'd0 ? "R2 status read" : addr == 2'd1 ? "R5 enable read" : "R9 unmapped read",
        rdata, exp_read(addr));
    evt = e; start = s; stop = p; wr = w; addr = a; wdata = d;
  endtask

  task automatic idle(logic [1:0] a);
    step('0, 0, 0, 0, a, '0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset values
    chk("R1 status", rdata, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 busy", {15'd0, busy}, 16'h0);
    rst_n = 1'b1;
    idle(2'd1); idle(2'd1);
    chk("R1 enable", rdata, 16'h0);

    // R2 / R8: every position pulsed; reserved ones stay clear
    step(16'hFFFF, 0, 0, 0, 2'd0, '0);
    idle(2'd0); idle(2'd0);
    chk("R8 reserved clear", rdata & 16'h70E0, 16'h0);
    chk("R2 latched", rdata, 16'h8F1F);

    // R3: clear selected flags only
    step('0, 0, 0, 1, 2'd0, 16'h0A05);
    idle(2'd0); idle(2'd0);
    chk("R3 partial clear", rdata, 16'h851A);

    // R4: event and clear in one cycle
    step(16'h0002, 0, 0, 1, 2'd0, 16'h0002);
    idle(2'd0);
    chk("R4 event wins", rdata & 16'h0002, 16'h0002);

    // R10: enable all, only high flags present -> no interrupt
    step('0, 0, 0, 1, 2'd0, 16'hFFFF);
    step('0, 0, 0, 1, 2'd1, 16'hFFFF);
    idle(2'd1); idle(2'd1);
    chk("R5 enable bits", rdata, 16'h001F);
    step(16'h8F00, 0, 0, 0, 2'd0, '0);
    idle(2'd0); idle(2'd0); idle(2'd0);
    chk("R10 no irq from high flags", {15'd0, irq}, 16'h0);

    // R6: timing of irq with a maskable flag
    step(16'h0008, 0, 0, 0, 2'd0, '0);
    idle(2'd0);
    chk("R6 not yet", {15'd0, irq}, 16'h0);
    idle(2'd0);
    chk("R6 raised", {15'd0, irq}, 16'h1);
    step('0, 0, 0, 1, 2'd0, 16'h0008);
    idle(2'd0);
    chk("R6 still high", {15'd0, irq}, 16'h1);
    idle(2'd0);
    chk("R6 dropped", {15'd0, irq}, 16'h0);

    // R7: busy tracking, start wins, write to bit 12 ignored
    step('0, 1, 0, 0, 2'd0, '0);
    step('0, 0, 0, 1, 2'd0, 16'h1000);
    idle(2'd0); idle(2'd0);
    chk("R7 busy unwritable", rdata & 16'h1000, 16'h1000);
    step('0, 1, 1, 0, 2'd0, '0);
    idle(2'd0); idle(2'd0);
    chk("R7 start wins", {15'd0, busy}, 16'h1);
    step('0, 0, 1, 0, 2'd0, '0);
    idle(2'd0); idle(2'd0);
    chk("R7 stop clears", {15'd0, busy}, 16'h0);

    // R9: unmapped writes change nothing
    step(16'h0001, 0, 0, 0, 2'd0, '0);
    step('0, 0, 0, 1, 2'd2, 16'hFFFF);
    step('0, 0, 0, 1, 2'd3, 16'hFFFF);
    idle(2'd0); idle(2'd0);
    chk("R9 status kept", rdata & 16'h0001, 16'h0001);
    idle(2'd1); idle(2'd1);
    chk("R9 enable kept", rdata, 16'h001F);

    // mixed traffic, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      step(16'($urandom & $urandom & $urandom), ($urandom % 8) == 0, ($urandom % 8) == 0,
           ($urandom % 4) == 0, 2'($urandom), 16'($urandom));
    end
    idle(2'd0); idle(2'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule